// File: doc/BRIEF.md
# Split-Access 64-bit Timestamp Counter

This block keeps a 64-bit reference time count that software reaches over a 32-bit register bus, one word at a time. The count advances by a fixed step of eight on every clock while time sync operation is on, so its three least significant bits are always zero. Software switches it on by setting one bit in a mode register.

To read the count without tearing, software first reads the low word. That read returns the low half of the live count and also freezes all 64 bits in a capture register. A later read of the high word returns the frozen upper half, even though the live count has kept running. To set the count, software first writes the low word, which is held in a staging register. A later write of the high word joins the two halves and loads the counter, which counts on from the new value. A second high-word write with no new low-word write between them is dropped.

Top module: `split_timestamp_counter`

## Requirements
- R1: After reset the counter, the capture register, the staging register, the pending flag and the mode register are all zero, so reads of every word return zero.
- R2: Word address 0 is the mode register. Only bit 19, the sync enable, can be written. All other bits read as zero.
- R3: While sync enable is 1 the counter grows by 8 on every clock. While it is 0 the counter holds its value.
- R4: A read at word address 1 returns bits [31:0] of the live count as it stood at the access edge. The same edge copies all 64 bits into the capture register, and the counter does not stop.
- R5: A read at word address 2 returns bits [63:32] of the capture register and never the live count. Before any low-word read since reset it returns zero.
- R6: A write at word address 1 stores the data into the staging register with bits [2:0] forced to zero and sets the pending flag. The live count does not change.
- R7: A write at word address 2 while the flag is pending loads {data, staged word} into the counter and clears the flag. The load wins over an increment in the same cycle, and counting resumes from the loaded value on the next clock.
- R8: A write at word address 2 while no low-word write is pending has no effect on the count.
- R9: Read data appears on the read data port one clock after the access. Word address 3 reads as zero.
- R10: Bits [2:0] of the count, and so of every low-word read, are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0 mode, 1 low word, 2 high word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one clock after a read access |

## Verification
The load path is tried with the counter stopped, so that reads show exactly the value that was loaded. A low-word write with nonzero bits [2:0] shows whether those bits are masked. A repeated high-word write shows whether the pending flag was consumed, and a high-word write straight after reset shows whether the flag started clear. With the counter running, low-word reads spaced a known number of clocks apart check the step of eight and whether the load took priority in its own cycle. A load just below a 32-bit boundary forces a carry into the upper word, so a high-word read taken after the carry shows whether the frozen capture or the live count was returned.

// File: rtl/tsc_pkg.sv
package tsc_pkg;
   // word addresses on the register bus
   localparam int unsigned WA_MODE = 0;
   localparam int unsigned WA_LOW  = 1;
   localparam int unsigned WA_HIGH = 2;
endpackage

// File: rtl/tsc_counter.sv
module tsc_counter #(
   parameter int unsigned CNT_W     = 64,
   parameter int unsigned FRAC_BITS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt
);
   localparam logic [CNT_W-1:0] STEP = CNT_W'(1) << FRAC_BITS;

   logic [CNT_W-1:0] load_masked;

   generate
      if (FRAC_BITS == 0) begin : g_nomask
         assign load_masked = load_val;
      end else begin : g_mask
         assign load_masked = {load_val[CNT_W-1:FRAC_BITS], {FRAC_BITS{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_masked;
      else if (en)   cnt <= cnt + STEP;
   end

   // R3: step when enabled and not loading
   p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && en) |=> (cnt - $past(cnt)) == STEP);
   // R3: hold when disabled
   p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !en) |=> $stable(cnt));

   generate
      if (FRAC_BITS > 0) begin : g_frac_chk
         // R10: fractional bits stay clear
         p_frac_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
            cnt[FRAC_BITS-1:0] == '0);
      end
   endgenerate
endmodule

// File: rtl/tsc_stage.sv
module tsc_stage #(
   parameter int unsigned BUS_W     = 32,
   parameter int unsigned FRAC_BITS = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lo_wr,
   input  logic             hi_wr,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] stage,
   output logic             pending
);
   logic [BUS_W-1:0] wmask;

   generate
      if (FRAC_BITS == 0) begin : g_nomask
         assign wmask = wdata;
      end else begin : g_mask
         assign wmask = {wdata[BUS_W-1:FRAC_BITS], {FRAC_BITS{1'b0}}};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage   <= '0;
         pending <= 1'b0;
      end else if (lo_wr) begin
         stage   <= wmask;
         pending <= 1'b1;
      end else if (hi_wr) begin
         pending <= 1'b0;
      end
   end

   // R6: a low write arms the pending flag
   p_pending_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr |=> pending);
   // R7: a high write consumes the flag
   p_pending_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_wr && !lo_wr) |=> !pending);
endmodule

// File: rtl/tsc_capture.sv
module tsc_capture #(
   parameter int unsigned CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cap_en,
   input  logic [CNT_W-1:0] cnt_in,
   output logic [CNT_W-1:0] cap_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cap_q <= '0;
      else if (cap_en) cap_q <= cnt_in;
   end

   // R5: the captured copy only moves on a low-word read
   p_cap_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(cap_q));
   // R4: a low-word read takes the live count of that edge
   p_cap_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
      cap_en |=> cap_q == $past(cnt_in));
endmodule

// File: rtl/split_timestamp_counter.sv
module split_timestamp_counter #(
   parameter int unsigned BUS_W       = 32,
   parameter int unsigned CNT_W       = 64,
   parameter int unsigned ADDR_W      = 2,
   parameter int unsigned FRAC_BITS   = 3,
   parameter int unsigned SYNC_EN_BIT = 19,
   parameter bit          REG_RDATA   = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata
);
   import tsc_pkg::*;

   localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(WA_MODE);
   localparam logic [ADDR_W-1:0] A_LOW  = ADDR_W'(WA_LOW);
   localparam logic [ADDR_W-1:0] A_HIGH = ADDR_W'(WA_HIGH);

   generate
      if (CNT_W != 2 * BUS_W) begin : g_bad_width
         $error("count width must be twice the bus width");
      end
      if (SYNC_EN_BIT >= BUS_W) begin : g_bad_bit
         $error("sync enable bit outside the bus word");
      end
      if (FRAC_BITS >= BUS_W) begin : g_bad_frac
         $error("fractional bits must fit in the low word");
      end
      if (ADDR_W < 2) begin : g_bad_addr
         $error("address too narrow for three registers");
      end
   endgenerate

   logic wr_acc, rd_acc;
   logic mode_wr, lo_wr, hi_wr, lo_rd;
   logic sync_en;
   logic load;
   logic pending;
   logic [BUS_W-1:0] stage;
   logic [CNT_W-1:0] cnt, cap_q;
   logic [BUS_W-1:0] rd_mux;

   assign wr_acc  = bus_sel &  bus_we;
   assign rd_acc  = bus_sel & ~bus_we;
   assign mode_wr = wr_acc && (bus_addr == A_MODE);
   assign lo_wr   = wr_acc && (bus_addr == A_LOW);
   assign hi_wr   = wr_acc && (bus_addr == A_HIGH);
   assign lo_rd   = rd_acc && (bus_addr == A_LOW);
   assign load    = hi_wr & pending;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       sync_en <= 1'b0;
      else if (mode_wr) sync_en <= bus_wdata[SYNC_EN_BIT];
   end

   tsc_counter #(.CNT_W(CNT_W), .FRAC_BITS(FRAC_BITS)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .en       (sync_en),
      .load     (load),
      .load_val ({bus_wdata, stage}),
      .cnt      (cnt)
   );

   tsc_stage #(.BUS_W(BUS_W), .FRAC_BITS(FRAC_BITS)) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .lo_wr   (lo_wr),
      .hi_wr   (hi_wr),
      .wdata   (bus_wdata),
      .stage   (stage),
      .pending (pending)
   );

   tsc_capture #(.CNT_W(CNT_W)) u_capture (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_en (lo_rd),
      .cnt_in (cnt),
      .cap_q  (cap_q)
   );

   always_comb begin
      rd_mux = '0;
      if (rd_acc) begin
         if (bus_addr == A_MODE)      rd_mux[SYNC_EN_BIT] = sync_en;
         else if (bus_addr == A_LOW)  rd_mux = cnt[BUS_W-1:0];
         else if (bus_addr == A_HIGH) rd_mux = cap_q[CNT_W-1:BUS_W];
      end
   end

   generate
      if (REG_RDATA) begin : g_rd_reg
         logic [BUS_W-1:0] rdata_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) rdata_q <= '0;
            else        rdata_q <= rd_mux;
         end
         assign bus_rdata = rdata_q;
      end else begin : g_rd_comb
         assign bus_rdata = rd_mux;
      end
   endgenerate

   // R8: a high write with nothing staged leaves the count as it would have been
   p_hi_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_wr && !pending && !sync_en) |=> $stable(cnt));
   // R7: a consumed high write loads both halves
   p_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (hi_wr && pending) |=> cnt[CNT_W-1:BUS_W] == $past(bus_wdata)
                             && cnt[BUS_W-1:0] == $past(stage));
   // R6: staging a low word does not touch a stopped count
   p_stage_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (lo_wr && !sync_en) |=> $stable(cnt));
endmodule

// File: tb/split_timestamp_counter_tb.sv
`timescale 1ns/1ps
module split_timestamp_counter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   split_timestamp_counter u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata)
   );

   // every access starts at a negedge and ends at the next one
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string req);
      logic [31:0] d;
      rd(a, d);
      check(req, d, exp);
   endtask

   task automatic t_reset;
      rd_check(2'd0, 32'h0, "R1 mode after reset");
      rd_check(2'd2, 32'h0, "R1/R5 high before any capture");
      rd_check(2'd1, 32'h0, "R1 low after reset");
      // R8: no pending low write after reset
      wr(2'd2, 32'h0000_0099);
      rd_check(2'd1, 32'h0, "R8 lone high write low word");
      rd_check(2'd2, 32'h0, "R8 lone high write high word");
   endtask

   task automatic t_mode;
      wr(2'd0, 32'hFFF7_FFFF);
      rd_check(2'd0, 32'h0, "R2 bit19 clear, others ignored");
      wr(2'd0, 32'hFFFF_FFFF);
      rd_check(2'd0, 32'h0008_0000, "R2 only bit19 sticks");
      wr(2'd0, 32'h0);
      rd_check(2'd3, 32'h0, "R9 unused address");
   endtask

   task automatic t_load_stopped;
      wr(2'd1, 32'h0000_0AB0);
      wr(2'd2, 32'h0000_0077);
      rd_check(2'd1, 32'h0000_0AB0, "R7 loaded low word");
      rd_check(2'd2, 32'h0000_0077, "R7 loaded high word");
      wr(2'd1, 32'h1234_567F);
      rd_check(2'd1, 32'h0000_0AB0, "R6 staging leaves count");
      wr(2'd2, 32'hCAFE_0000);
      rd_check(2'd1, 32'h1234_5678, "R6/R10 staged bits 2:0 cleared");
      rd_check(2'd2, 32'hCAFE_0000, "R7 second load high word");
      wr(2'd2, 32'h1111_0000);
      rd_check(2'd1, 32'h1234_5678, "R8 repeated high write low");
      rd_check(2'd2, 32'hCAFE_0000, "R8 repeated high write high");
   endtask

   task automatic t_running;
      wr(2'd0, 32'h0008_0000);
      wr(2'd1, 32'h0000_1000);
      wr(2'd2, 32'h0000_0002);          // load edge
      rd_check(2'd1, 32'h0000_1000, "R7 load wins over increment");
      idle(4);
      rd_check(2'd1, 32'h0000_1028, "R3/R4 step of 8 per clock");
      rd_check(2'd2, 32'h0000_0002, "R5 high of capture");
   endtask

   task automatic t_carry;
      wr(2'd1, 32'hFFFF_FFF8);
      wr(2'd2, 32'h0000_0005);
      rd_check(2'd1, 32'hFFFF_FFF8, "R4 capture below boundary");
      idle(3);
      rd_check(2'd2, 32'h0000_0005, "R5 frozen high, not live");
      rd_check(2'd1, 32'h0000_0020, "R3 count past carry");
      rd_check(2'd2, 32'h0000_0006, "R4 carry into high word");
   endtask

   task automatic t_hold;
      logic [31:0] a, b;
      wr(2'd0, 32'h0);
      rd(2'd1, a);
      idle(5);
      rd(2'd1, b);
      check("R3 hold while disabled", b, a);
      check("R10 low bits zero", {29'h0, b[2:0]}, 32'h0);
   endtask

   initial begin
      #(20 * 200000);
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_mode();
      t_load_stopped();
      t_running();
      t_carry();
      t_hold();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule